// File: doc/BRIEF.md
# Line-Repeat Vertical Scaling Read Controller

This block sequences the read side of a scan converter that stores incoming video lines and plays them back at a higher line rate. It runs in the read clock domain. It measures the period of the incoming line strobe, derives the output line timing from it, and decides which stored line is read next and how many times it is read.

In standard and wide operation every stored line is read twice, which gives a plain doubling of the line rate. In enlargement operation stored lines alternate between two reads and three reads. That averages 2.5 output lines per input line and stretches the picture 1.25 times vertically. The block also reports the horizontal sample count the write side should use for the selected operation. For 625-line input only standard operation exists, and any other request falls back to it.

A new operating choice is taken only on a field-start strobe, so a field is never split between two behaviours. Each field-start strobe also restarts the line index and the repeat pattern.

Top module: `line_repeat_ctrl`

## Requirements
- R1: After reset, line_rst, hsync_out, line_idx, rep_num and triple are all 0, and h_samples is 832.
- R2: In standard or wide operation, output lines after a field start read stored line n/2 with rep_num = n mod 2, and triple stays 0.
- R3: In enlargement operation, stored lines alternate between two reads (triple = 0) and three reads (triple = 1). The even-numbered lines from the field start are the two-read ones. rep_num counts 0,1 or 0,1,2.
- R4: A field_stb makes the next cycle a line start with line_idx = 0, rep_num = 0 and triple = 0.
- R5: P is the number of clock cycles between consecutive in_line_stb pulses. Output line n after a field start begins ceil(n*M/S) cycles after the field-start line. M = P and S = 2 in standard or wide operation. M = 2P and S = 5 in enlargement operation.
- R6: line_rst is a one-cycle pulse per output line start. line_idx changes only at a line start and advances by one only after the last repeat of a line.
- R7: hsync_out is high for HS_W cycles (default 8), beginning in the cycle of line_rst.
- R8: mode_sel encodes 0 = standard, 1 = enlargement, 2 = wide, 3 = standard. h_samples is 832, 1028, 1068 and 832 for these codes respectively.
- R9: When is_625 is 1, the block behaves as standard for every mode_sel value, and h_samples is 942.
- R10: mode_sel and is_625 take effect only at a field_stb. A change in mid-field leaves the line sequence and h_samples unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Requested operation (0 std, 1 enlarge, 2 wide, 3 std) |
| is_625 | input | 1 | Input is 625-line video |
| in_line_stb | input | 1 | Input line strobe, already in the read domain |
| field_stb | input | 1 | Field start strobe |
| line_rst | output | 1 | One-cycle pulse at each output line start |
| line_idx | output | IDX_W | Stored line being read |
| rep_num | output | 2 | Repeat number of the current read |
| triple | output | 1 | Current stored line is a three-read line |
| hsync_out | output | 1 | Output horizontal sync |
| h_samples | output | 11 | Horizontal sample count for the write side |

## Verification
The bench runs all four mode codes under both line standards, with an odd and an even input line period. The odd period separates correct ceiling-rounded line lengths from truncated ones. The enlargement runs separate the 2/3 pattern from a plain doubling. Each run flips mode_sel in mid-field, which shows whether a mode change leaks in before the next field start. Every cycle of each field window is compared with line-start instants and sync widths computed arithmetically.

// File: rtl/lr_pkg.sv
package lr_pkg;
  typedef enum logic [1:0] {
    LR_STD  = 2'd0,
    LR_ENL  = 2'd1,
    LR_WIDE = 2'd2
  } lr_mode_e;

  localparam logic [10:0] SAMP_STD  = 11'd832;
  localparam logic [10:0] SAMP_ENL  = 11'd1028;
  localparam logic [10:0] SAMP_WIDE = 11'd1068;
  localparam logic [10:0] SAMP_625  = 11'd942;

  function automatic lr_mode_e lr_resolve(input logic [1:0] sel, input logic is625);
    lr_mode_e m;
    if (is625)            m = LR_STD;
    else if (sel == 2'd1) m = LR_ENL;
    else if (sel == 2'd2) m = LR_WIDE;
    else                  m = LR_STD;
    return m;
  endfunction

  function automatic logic [10:0] lr_samples(input lr_mode_e m, input logic is625);
    logic [10:0] s;
    if (is625)             s = SAMP_625;
    else if (m == LR_ENL)  s = SAMP_ENL;
    else if (m == LR_WIDE) s = SAMP_WIDE;
    else                   s = SAMP_STD;
    return s;
  endfunction
endpackage

// File: rtl/lr_period_meas.sv
module lr_period_meas #(
  parameter int PER_W    = 12,
  parameter int MIN_PER  = 16,
  parameter int INIT_PER = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_stb,
  output logic [PER_W-1:0] per
);
  localparam logic [PER_W-1:0] CNT_MAX = {PER_W{1'b1}};
  localparam logic [PER_W:0]   MIN_W   = (PER_W+1)'(MIN_PER);

  logic [PER_W-1:0] cnt_q, cnt_d, per_q, per_d;
  logic [PER_W:0]   meas;

  always_comb begin
    meas  = {1'b0, cnt_q} + 1'b1;
    cnt_d = cnt_q;
    per_d = per_q;
    if (in_stb) begin
      cnt_d = '0;
      if (meas < MIN_W)     per_d = MIN_W[PER_W-1:0];
      else if (meas[PER_W]) per_d = CNT_MAX;
      else                  per_d = meas[PER_W-1:0];
    end else if (cnt_q != CNT_MAX) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      per_q <= PER_W'(INIT_PER);
    end else begin
      cnt_q <= cnt_d;
      per_q <= per_d;
    end
  end

  assign per = per_q;
endmodule

// File: rtl/lr_line_dda.sv
module lr_line_dda #(
  parameter int PER_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             enl,
  input  logic [PER_W-1:0] per,
  output logic             tick
);
  localparam int AW = PER_W + 2;

  logic [AW-1:0] acc_q, acc_d, sum, modv;

  always_comb begin
    modv  = enl ? {1'b0, per, 1'b0} : {2'b00, per};
    sum   = acc_q + (enl ? AW'(5) : AW'(2));
    tick  = !restart && (sum >= modv);
    if (restart)   acc_d = '0;
    else if (tick) acc_d = sum - modv;
    else           acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/lr_repeat_seq.sv
module lr_repeat_seq #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             tick,
  input  logic             enl,
  output logic [IDX_W-1:0] idx,
  output logic [1:0]       rep,
  output logic             tri3
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [1:0]       rep_q, rep_d, last;
  logic             tri_q, tri_d;

  always_comb begin
    last  = tri_q ? 2'd2 : 2'd1;
    idx_d = idx_q;
    rep_d = rep_q;
    tri_d = tri_q;
    if (restart) begin
      idx_d = '0;
      rep_d = '0;
      tri_d = 1'b0;
    end else if (tick) begin
      if (rep_q == last) begin
        rep_d = '0;
        idx_d = idx_q + 1'b1;
        tri_d = enl & ~tri_q;
      end else begin
        rep_d = rep_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      rep_q <= '0;
      tri_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      rep_q <= rep_d;
      tri_q <= tri_d;
    end
  end

  assign idx  = idx_q;
  assign rep  = rep_q;
  assign tri3 = tri_q;
endmodule

// File: rtl/line_repeat_ctrl.sv
module line_repeat_ctrl #(
  parameter int PER_W    = 12,
  parameter int MIN_PER  = 16,
  parameter int INIT_PER = 64,
  parameter int IDX_W    = 10,
  parameter int HS_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             is_625,
  input  logic             in_line_stb,
  input  logic             field_stb,
  output logic             line_rst,
  output logic [IDX_W-1:0] line_idx,
  output logic [1:0]       rep_num,
  output logic             triple,
  output logic             hsync_out,
  output logic [10:0]      h_samples
);
  import lr_pkg::*;

  localparam int HC_W = $clog2(HS_W + 1);

  lr_mode_e         mode_q, mode_d;
  logic             is625_q, is625_d;
  logic             enl, tick;
  logic             lrst_q, lrst_d;
  logic [HC_W-1:0]  hs_q, hs_d;
  logic [PER_W-1:0] per;

  assign enl = (mode_q == LR_ENL);

  lr_period_meas #(.PER_W(PER_W), .MIN_PER(MIN_PER), .INIT_PER(INIT_PER)) meas_i (
    .clk(clk), .rst_n(rst_n), .in_stb(in_line_stb), .per(per)
  );

  lr_line_dda #(.PER_W(PER_W)) dda_i (
    .clk(clk), .rst_n(rst_n), .restart(field_stb), .enl(enl), .per(per), .tick(tick)
  );

  lr_repeat_seq #(.IDX_W(IDX_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .restart(field_stb), .tick(tick), .enl(enl),
    .idx(line_idx), .rep(rep_num), .tri3(triple)
  );

  always_comb begin
    mode_d  = mode_q;
    is625_d = is625_q;
    if (field_stb) begin
      mode_d  = lr_resolve(mode_sel, is_625);
      is625_d = is_625;
    end
    lrst_d = field_stb | tick;
    if (lrst_d)         hs_d = HC_W'(HS_W);
    else if (hs_q != 0) hs_d = hs_q - 1'b1;
    else                hs_d = hs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= LR_STD;
      is625_q <= 1'b0;
      lrst_q  <= 1'b0;
      hs_q    <= '0;
    end else begin
      mode_q  <= mode_d;
      is625_q <= is625_d;
      lrst_q  <= lrst_d;
      hs_q    <= hs_d;
    end
  end

  assign line_rst  = lrst_q;
  assign hsync_out = (hs_q != 0);
  assign h_samples = lr_samples(mode_q, is625_q);
endmodule

// File: rtl/lr_chk.sv
module lr_chk #(
  parameter int IDX_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             field_stb,
  input logic             line_rst,
  input logic [IDX_W-1:0] line_idx,
  input logic [1:0]       rep_num,
  input logic             triple,
  input logic             hsync_out,
  input logic [10:0]      h_samples
);
  AST_FIELD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    field_stb |=> (line_rst && line_idx == '0 && rep_num == 2'd0 && !triple)); // R4
  AST_RST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rst && !field_stb) |=> !line_rst); // R6
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !line_rst |-> $stable(line_idx)); // R6
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (line_rst && !$past(field_stb) && rep_num == 2'd0) |-> line_idx == $past(line_idx) + 1'b1); // R6
  AST_REP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rep_num <= (triple ? 2'd2 : 2'd1)); // R3
  AST_TRIPLE_ENL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (h_samples != 11'd1028) |-> !triple); // R2
  AST_HSYNC_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    line_rst |-> hsync_out); // R7
  AST_SAMPLES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (h_samples == 11'd832 || h_samples == 11'd1028 || h_samples == 11'd1068 || h_samples == 11'd942)); // R8
  AST_SAMPLES_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(field_stb) |-> $stable(h_samples)); // R10
endmodule

bind line_repeat_ctrl lr_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .field_stb(field_stb), .line_rst(line_rst),
  .line_idx(line_idx), .rep_num(rep_num), .triple(triple),
  .hsync_out(hsync_out), .h_samples(h_samples)
);

// File: tb/line_repeat_ctrl_tb_top.sv
`timescale 1ns/1ps
module line_repeat_ctrl_tb_top;
  localparam int IDX_W = 10;
  localparam int HS_W  = 8;
  localparam int KMAX  = 260;

  logic clk, rst_n, is_625, in_line_stb, field_stb;
  logic [1:0] mode_sel;
  logic line_rst, triple, hsync_out;
  logic [IDX_W-1:0] line_idx;
  logic [1:0] rep_num;
  logic [10:0] h_samples;

  int total = 0, bad = 0, cyc = 0, per_p = 41;
  bit stb_en = 0, done = 0;

  line_repeat_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .is_625(is_625),
    .in_line_stb(in_line_stb), .field_stb(field_stb), .line_rst(line_rst),
    .line_idx(line_idx), .rep_num(rep_num), .triple(triple),
    .hsync_out(hsync_out), .h_samples(h_samples)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) in_line_stb <= stb_en && (cyc % per_p == 0);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_field(input int p, input int msel, input bit f625);
    int enl, m, s, n, last, nxt, e_idx, e_rep, e_tri, e_samp;
    per_p = p;
    repeat (3 * p + 2) @(negedge clk);
    mode_sel = msel[1:0];
    is_625 = f625;
    enl = (!f625 && msel == 1) ? 1 : 0;
    m = enl ? 2 * p : p;
    s = enl ? 5 : 2;
    e_samp = f625 ? 942 : (msel == 1 ? 1028 : (msel == 2 ? 1068 : 832));
    field_stb = 1;
    @(posedge clk);
    @(negedge clk);
    field_stb = 0;
    n = 0;
    last = 0;
    for (int k = 0; k <= KMAX; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 100) mode_sel = 2'((msel + 1) % 4);
      if (k == 140) is_625 = !f625;
      nxt = (n * m + s - 1) / s;
      if (k == nxt) begin
        // R5 line start instant, R6 single pulse
        chk(line_rst == 1'b1, "R5", int'(line_rst), 1);
        if (enl) begin
          e_idx = 2 * (n / 5) + ((n % 5) < 2 ? 0 : 1);
          e_rep = (n % 5) < 2 ? n % 5 : (n % 5) - 2;
          e_tri = (n % 5) < 2 ? 0 : 1;
        end else begin
          e_idx = n / 2;
          e_rep = n % 2;
          e_tri = 0;
        end
        if (n == 0) chk(line_idx == 0 && rep_num == 0 && !triple, "R4", int'(line_idx), 0);
        chk(int'(line_idx) == e_idx, enl ? "R3 idx" : (f625 ? "R9 idx" : "R2 idx"), int'(line_idx), e_idx);
        chk(int'(rep_num) == e_rep, enl ? "R3 rep" : "R2 rep", int'(rep_num), e_rep);
        chk(int'(triple) == e_tri, enl ? "R3 triple" : "R9 triple", int'(triple), e_tri);
        last = k;
        n++;
      end else begin
        chk(line_rst == 1'b0, "R6", int'(line_rst), 0);
      end
      chk(int'(hsync_out) == ((k - last) < HS_W ? 1 : 0), "R7", int'(hsync_out), (k - last) < HS_W ? 1 : 0);
      // R8 sample count, R10 mid-field change ignored
      if (k == 0 || k == KMAX)
        chk(int'(h_samples) == e_samp, k == 0 ? (f625 ? "R9 samples" : "R8") : "R10", int'(h_samples), e_samp);
    end
  endtask

  initial begin
    rst_n = 0; mode_sel = 0; is_625 = 0; field_stb = 0; in_line_stb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!line_rst && !hsync_out, "R1 pulses", int'(line_rst) + int'(hsync_out), 0);
    chk(line_idx == 0 && rep_num == 0 && !triple, "R1 idx", int'(line_idx), 0);
    chk(h_samples == 11'd832, "R1 samples", int'(h_samples), 832);
    stb_en = 1;
    for (int pi = 0; pi < 2; pi++)
      for (int f = 0; f < 2; f++)
        for (int md = 0; md < 4; md++)
          run_field(pi == 0 ? 41 : 50, md, f[0]);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule